// File: doc/BRIEF.md
# Security-Banked Tick Timer Register Router

This block sits between a processor's memory-mapped request path and two register files of a system tick timer. One register file serves the secure world and the other the non-secure world. Each incoming request carries an address, a read or write flag, write data, an access size, a secure attribute and an unprivileged (user) attribute. The router decides whether it owns the address. If it does, it either forwards the access to one of the two timer banks or completes the access itself.

There are two address windows, each 0xE0 bytes long. The main window starts at 0xE000E010. In this window the secure attribute of the caller selects the bank. A second window starts at 0xE002E010 and is an alias that gives secure code a non-secure view of the timer. Non-secure callers get a benign or faulting reply from it. The alias window is only decoded when the newer-architecture configuration input is set. The secure bank only exists when the security-extension configuration input is set. Each bank's interrupt line is passed on toward the interrupt controller.

An accepted access is registered once. In the next cycle the router drives a single strobe to the chosen bank and returns that bank's read data and error flag, or its own local reply.

Top module: `tick_bank_router`

## Requirements
- R1: The main window covers addresses 0xE000E010 up to 0xE000E0EF inclusive, and the alias window covers 0xE002E010 up to 0xE002E0EF. The offset given to a bank is the request address minus the base of the window that was hit, 8 bits wide.
- R2: With `cfg_sec_ext`=1, a main-window access with `req_sec`=1 strobes only the secure bank (`s_vld`). With `req_sec`=0 it strobes only the non-secure bank (`ns_vld`).
- R3: With `cfg_sec_ext`=0, every main-window access strobes the non-secure bank, whatever the value of `req_sec`, and `s_vld` never rises.
- R4: With `cfg_v8`=0, an alias-window address is not claimed.
- R5: A secure access (`req_sec`=1) to the decoded alias window strobes the non-secure bank.
- R6: A non-secure access (`req_sec`=0) with `req_user`=0 to the decoded alias window strobes no bank. It completes with `rsp_rdata`=0 and `rsp_err`=0.
- R7: A non-secure access with `req_user`=1 to the decoded alias window strobes no bank. It completes with `rsp_err`=1 and `rsp_rdata`=0.
- R8: An address outside both decoded windows keeps `req_hit` low in the request cycle. It strobes no bank and produces no `rsp_vld`.
- R9: A claimed request in cycle N gives `rsp_vld`=1 in cycle N+1, and only then. A forwarded access asserts exactly one bank strobe in cycle N+1. For a forwarded access, `rsp_rdata` and `rsp_err` equal that bank's `*_rdata` and `*_err` in that cycle.
- R10: A forwarded access presents the request's write flag, write data, size and user attribute unchanged at the bank port.
- R11: `irq_ns_o` follows `ns_tick_irq`. `irq_s_o` follows `s_tick_irq` when `cfg_sec_ext`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sec_ext | input | 1 | Security extension present, enables the secure bank |
| cfg_v8 | input | 1 | Newer architecture level, enables the alias window |
| req_vld | input | 1 | Request valid |
| req_addr | input | 32 | Request byte address |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access size code, passed through |
| req_sec | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| req_hit | output | 1 | Address claimed (combinational, request cycle) |
| rsp_vld | output | 1 | Response valid |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Error (bus fault) response |
| ns_vld | output | 1 | Non-secure bank strobe |
| ns_wr | output | 1 | Non-secure bank write flag |
| ns_off | output | 8 | Non-secure bank offset |
| ns_wdata | output | 32 | Non-secure bank write data |
| ns_size | output | 2 | Non-secure bank size |
| ns_user | output | 1 | Non-secure bank user attribute |
| ns_rdata | input | 32 | Non-secure bank read data |
| ns_err | input | 1 | Non-secure bank error |
| s_vld | output | 1 | Secure bank strobe |
| s_wr | output | 1 | Secure bank write flag |
| s_off | output | 8 | Secure bank offset |
| s_wdata | output | 32 | Secure bank write data |
| s_size | output | 2 | Secure bank size |
| s_user | output | 1 | Secure bank user attribute |
| s_rdata | input | 32 | Secure bank read data |
| s_err | input | 1 | Secure bank error |
| ns_tick_irq | input | 1 | Interrupt from the non-secure bank |
| s_tick_irq | input | 1 | Interrupt from the secure bank |
| irq_ns_o | output | 1 | Non-secure tick interrupt out |
| irq_s_o | output | 1 | Secure tick interrupt out |

## Verification
The assertions assume that `cfg_sec_ext` and `cfg_v8` hold steady across the two cycles of any access. They also assume that each bank answers combinationally in the cycle its strobe is high. The stimulus follows both assumptions. It changes the configuration inputs only in an idle cycle between accesses. Its bank models compute read data and error purely from the strobed port fields. The sweep covers every combination of the two configuration bits, the secure and user attributes and the read/write flag. Each combination is applied to addresses at the base, at an interior offset, at the last word and one step outside each window, and at an unrelated address.

// File: rtl/tick_route_pkg.sv
package tick_route_pkg;
   typedef enum logic [2:0] {
      RT_NONE  = 3'd0,
      RT_NSEC  = 3'd1,
      RT_SEC   = 3'd2,
      RT_RAZ   = 3'd3,
      RT_FAULT = 3'd4
   } route_e;
endpackage

// File: rtl/tick_win_decode.sv
module tick_win_decode #(
   parameter int unsigned           ADDR_W = 32,
   parameter int unsigned           OFF_W  = 8,
   parameter logic [ADDR_W-1:0]     BASE   = '0,
   parameter int unsigned           SPAN   = 224
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [OFF_W-1:0]  off
);
   localparam logic [ADDR_W-1:0] LIMIT = BASE + ADDR_W'(SPAN);

   if (SPAN > (1 << OFF_W)) begin : g_bad_span
      $error("tick_win_decode: SPAN does not fit OFF_W");
   end

   always_comb begin
      hit = (addr >= BASE) && (addr < LIMIT);
      off = OFF_W'(addr - BASE);
   end
endmodule

// File: rtl/tick_route_select.sv
module tick_route_select
   import tick_route_pkg::*;
(
   input  logic   pri_hit,
   input  logic   ali_hit,
   input  logic   sec,
   input  logic   user,
   input  logic   sec_ext,
   output route_e route
);
   always_comb begin
      route = RT_NONE;
      if (pri_hit) begin
         route = (sec && sec_ext) ? RT_SEC : RT_NSEC;
      end else if (ali_hit) begin
         if (sec)       route = RT_NSEC;
         else if (user) route = RT_FAULT;
         else           route = RT_RAZ;
      end
   end
endmodule

// File: rtl/tick_resp_mux.sv
module tick_resp_mux
   import tick_route_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_q,
   input  route_e            route_q,
   input  logic [DATA_W-1:0] ns_rdata,
   input  logic              ns_err,
   input  logic [DATA_W-1:0] s_rdata,
   input  logic              s_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   always_comb begin
      rsp_rdata = '0;
      rsp_err   = 1'b0;
      if (vld_q) begin
         unique case (route_q)
            RT_NSEC:  begin rsp_rdata = ns_rdata; rsp_err = ns_err; end
            RT_SEC:   begin rsp_rdata = s_rdata;  rsp_err = s_err;  end
            RT_FAULT: rsp_err = 1'b1;
            default:  ;
         endcase
      end
   end

   AST_RAZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && route_q == RT_RAZ) |-> (rsp_rdata == '0 && !rsp_err)); // R6
   AST_FAULT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && route_q == RT_FAULT) |-> (rsp_err && rsp_rdata == '0)); // R7
   AST_BANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && route_q == RT_SEC) |-> (rsp_rdata == s_rdata && rsp_err == s_err)); // R9
endmodule

// File: rtl/tick_bank_router.sv
module tick_bank_router
   import tick_route_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 32,
   parameter int unsigned       DATA_W        = 32,
   parameter int unsigned       SIZE_W        = 2,
   parameter int unsigned       WIN_SPAN      = 224,
   parameter logic [ADDR_W-1:0] PRI_BASE      = 32'hE000_E010,
   parameter logic [ADDR_W-1:0] ALI_BASE      = 32'hE002_E010,
   parameter bit                HAS_ALIAS_WIN = 1'b1,
   localparam int unsigned      OFF_W         = $clog2(WIN_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sec_ext,
   input  logic              cfg_v8,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_sec,
   input  logic              req_user,
   output logic              req_hit,
   output logic              rsp_vld,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              ns_vld,
   output logic              ns_wr,
   output logic [OFF_W-1:0]  ns_off,
   output logic [DATA_W-1:0] ns_wdata,
   output logic [SIZE_W-1:0] ns_size,
   output logic              ns_user,
   input  logic [DATA_W-1:0] ns_rdata,
   input  logic              ns_err,
   output logic              s_vld,
   output logic              s_wr,
   output logic [OFF_W-1:0]  s_off,
   output logic [DATA_W-1:0] s_wdata,
   output logic [SIZE_W-1:0] s_size,
   output logic              s_user,
   input  logic [DATA_W-1:0] s_rdata,
   input  logic              s_err,
   input  logic              ns_tick_irq,
   input  logic              s_tick_irq,
   output logic              irq_ns_o,
   output logic              irq_s_o
);
   if (WIN_SPAN == 0 || DATA_W % 8 != 0) begin : g_bad_geom
      $error("tick_bank_router: bad WIN_SPAN or DATA_W");
   end
   if (!((64'(PRI_BASE) + WIN_SPAN <= 64'(ALI_BASE)) ||
         (64'(ALI_BASE) + WIN_SPAN <= 64'(PRI_BASE)))) begin : g_bad_overlap
      $error("tick_bank_router: windows overlap");
   end
   if (64'(PRI_BASE) + WIN_SPAN > (64'd1 << ADDR_W) ||
       64'(ALI_BASE) + WIN_SPAN > (64'd1 << ADDR_W)) begin : g_bad_wrap
      $error("tick_bank_router: window wraps the address space");
   end

   logic             pri_hit, ali_hit;
   logic [OFF_W-1:0] pri_off, ali_off;
   route_e           route_d, route_q;
   logic             vld_q, wr_q, user_q;
   logic [OFF_W-1:0] off_q;
   logic [DATA_W-1:0] wdata_q;
   logic [SIZE_W-1:0] size_q;

   tick_win_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE(PRI_BASE), .SPAN(WIN_SPAN))
   i_pri_dec (.addr(req_addr), .hit(pri_hit), .off(pri_off));

   if (HAS_ALIAS_WIN) begin : g_alias
      logic ali_raw;
      tick_win_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE(ALI_BASE), .SPAN(WIN_SPAN))
      i_ali_dec (.addr(req_addr), .hit(ali_raw), .off(ali_off));
      assign ali_hit = ali_raw && cfg_v8;
   end else begin : g_no_alias
      logic unused_v8;
      assign unused_v8 = cfg_v8;
      assign ali_hit   = 1'b0;
      assign ali_off   = '0;
   end

   tick_route_select i_sel (
      .pri_hit(pri_hit), .ali_hit(ali_hit), .sec(req_sec), .user(req_user),
      .sec_ext(cfg_sec_ext), .route(route_d));

   assign req_hit = pri_hit || ali_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         route_q <= RT_NONE;
         wr_q    <= 1'b0;
         user_q  <= 1'b0;
         off_q   <= '0;
         wdata_q <= '0;
         size_q  <= '0;
      end else begin
         vld_q <= req_vld && req_hit;
         if (req_vld && req_hit) begin
            route_q <= route_d;
            wr_q    <= req_wr;
            user_q  <= req_user;
            off_q   <= pri_hit ? pri_off : ali_off;
            wdata_q <= req_wdata;
            size_q  <= req_size;
         end
      end
   end

   assign rsp_vld  = vld_q;
   assign ns_vld   = vld_q && (route_q == RT_NSEC);
   assign s_vld    = vld_q && (route_q == RT_SEC);
   assign ns_wr    = wr_q;
   assign ns_off   = off_q;
   assign ns_wdata = wdata_q;
   assign ns_size  = size_q;
   assign ns_user  = user_q;
   assign s_wr     = wr_q;
   assign s_off    = off_q;
   assign s_wdata  = wdata_q;
   assign s_size   = size_q;
   assign s_user   = user_q;

   tick_resp_mux #(.DATA_W(DATA_W)) i_rsp (
      .clk(clk), .rst_n(rst_n), .vld_q(vld_q), .route_q(route_q),
      .ns_rdata(ns_rdata), .ns_err(ns_err), .s_rdata(s_rdata), .s_err(s_err),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

   assign irq_ns_o = ns_tick_irq;
   assign irq_s_o  = s_tick_irq && cfg_sec_ext;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ns_vld && s_vld)); // R9
   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_hit) |=> rsp_vld); // R9
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_hit) |=> (!rsp_vld && !ns_vld && !s_vld)); // R8
   AST_SEC_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld |-> cfg_sec_ext); // R3
   AST_ALIAS_NEEDS_V8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_hit && !pri_hit) |-> cfg_v8); // R4
endmodule

// File: tb/test_tick_bank_router.sv
module test_tick_bank_router;
   localparam logic [31:0] PB = 32'hE000_E010;
   localparam logic [31:0] AB = 32'hE002_E010;
   localparam logic [31:0] SP = 32'h0000_00E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sec_ext = 1'b0, cfg_v8 = 1'b0;
   logic        req_vld = 1'b0, req_wr = 1'b0, req_sec = 1'b0, req_user = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_size = '0;
   logic        req_hit, rsp_vld, rsp_err;
   logic [31:0] rsp_rdata;
   logic        ns_vld, ns_wr, ns_user, s_vld, s_wr, s_user;
   logic [7:0]  ns_off, s_off;
   logic [31:0] ns_wdata, s_wdata, ns_rdata, s_rdata;
   logic [1:0]  ns_size, s_size;
   logic        ns_err, s_err;
   logic        ns_tick_irq = 1'b0, s_tick_irq = 1'b0, irq_ns_o, irq_s_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   // bank models: data and error depend only on strobed fields
   always_comb begin
      ns_rdata = {8'h4E, 7'b0, ns_user, 6'b0, ns_size, ns_off};
      ns_err   = ns_wr && (ns_off == 8'hDC);
      s_rdata  = {8'h53, 7'b0, s_user, 6'b0, s_size, s_off};
      s_err    = s_wr && (s_off == 8'hDC);
   end

   tick_bank_router i_tick_bank_router (
      .clk(clk), .rst_n(rst_n), .cfg_sec_ext(cfg_sec_ext), .cfg_v8(cfg_v8),
      .req_vld(req_vld), .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
      .req_size(req_size), .req_sec(req_sec), .req_user(req_user), .req_hit(req_hit),
      .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .ns_vld(ns_vld), .ns_wr(ns_wr), .ns_off(ns_off), .ns_wdata(ns_wdata),
      .ns_size(ns_size), .ns_user(ns_user), .ns_rdata(ns_rdata), .ns_err(ns_err),
      .s_vld(s_vld), .s_wr(s_wr), .s_off(s_off), .s_wdata(s_wdata),
      .s_size(s_size), .s_user(s_user), .s_rdata(s_rdata), .s_err(s_err),
      .ns_tick_irq(ns_tick_irq), .s_tick_irq(s_tick_irq),
      .irq_ns_o(irq_ns_o), .irq_s_o(irq_s_o));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // route codes: 0 none, 1 non-secure bank, 2 secure bank, 3 zero/ignore, 4 fault
   task automatic access(input logic [31:0] addr, input bit wr, input bit sec, input bit user,
                         input logic [1:0] size);
      bit pri, ali;
      int r;
      logic [7:0] off;
      logic [31:0] wd, exp_rd;
      bit exp_err;
      string tag;
      pri = (addr >= PB) && (addr < PB + SP);
      ali = cfg_v8 && (addr >= AB) && (addr < AB + SP);
      r = 0;
      if (pri) r = (sec && cfg_sec_ext) ? 2 : 1;
      else if (ali) r = sec ? 1 : (user ? 4 : 3);
      off = pri ? 8'(addr - PB) : 8'(addr - AB);
      wd  = addr ^ 32'h5A5A_0F0F ^ {31'b0, wr};
      if (r == 0) tag = (!cfg_v8 && addr >= AB && addr < AB + SP) ? "R4" : "R8";
      else if (r == 2) tag = "R2";
      else if (pri) tag = (sec && !cfg_sec_ext) ? "R3" : "R2";
      else if (r == 1) tag = "R5";
      else if (r == 3) tag = "R6";
      else tag = "R7";

      @(negedge clk);
      chk(rsp_vld == 1'b0, "R9 idle rsp_vld", {31'b0, rsp_vld}, 32'd0);
      req_vld = 1'b1; req_addr = addr; req_wr = wr; req_sec = sec;
      req_user = user; req_size = size; req_wdata = wd;
      #1;
      chk(req_hit == (r != 0), tag, {31'b0, req_hit}, {31'b0, r != 0});
      @(negedge clk);
      chk(ns_vld == (r == 1) && s_vld == (r == 2), tag, {30'b0, s_vld, ns_vld},
          {30'b0, r == 2, r == 1});
      chk(rsp_vld == (r != 0), "R9 rsp_vld", {31'b0, rsp_vld}, {31'b0, r != 0});
      if (r == 1 || r == 2) begin
         logic [7:0] aoff; logic [31:0] awd; logic [1:0] asz; logic awr, ausr;
         aoff = (r == 1) ? ns_off : s_off;
         awd  = (r == 1) ? ns_wdata : s_wdata;
         asz  = (r == 1) ? ns_size : s_size;
         awr  = (r == 1) ? ns_wr : s_wr;
         ausr = (r == 1) ? ns_user : s_user;
         chk(aoff == off, "R1 offset", {24'b0, aoff}, {24'b0, off});
         chk(awd == wd && asz == size && awr == wr && ausr == user, "R10 fields",
             {awd[27:0], asz, awr, ausr}, {wd[27:0], size, wr, user});
         exp_rd  = {(r == 1) ? 8'h4E : 8'h53, 7'b0, user, 6'b0, size, off};
         exp_err = wr && (off == 8'hDC);
         chk(rsp_rdata == exp_rd && rsp_err == exp_err, "R9 bank reply",
             rsp_rdata ^ {31'b0, rsp_err}, exp_rd ^ {31'b0, exp_err});
      end else if (r == 3 || r == 4) begin
         chk(rsp_rdata == 32'd0 && rsp_err == (r == 4), tag,
             rsp_rdata | {31'b0, rsp_err}, {31'b0, r == 4});
      end
      req_vld = 1'b0;
   endtask

   initial begin
      #200000000;
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] addrs [8];
      addrs[0] = PB;        addrs[1] = PB + 32'hDC; addrs[2] = PB + SP; addrs[3] = PB - 32'd4;
      addrs[4] = AB;        addrs[5] = AB + 32'h40; addrs[6] = AB + SP; addrs[7] = 32'h0000_1000;
      repeat (3) @(negedge clk);
      chk(rsp_vld == 0 && ns_vld == 0 && s_vld == 0, "R9 reset",
          {29'b0, rsp_vld, ns_vld, s_vld}, 32'd0);
      rst_n = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         cfg_sec_ext = c[0]; cfg_v8 = c[1];
         for (int a = 0; a < 8; a++)
            for (int m = 0; m < 8; m++)
               access(addrs[a], m[0], m[1], m[2], 2'(a + m));
         for (int q = 0; q < 4; q++) begin
            ns_tick_irq = q[0]; s_tick_irq = q[1];
            #1;
            chk(irq_ns_o == q[0] && irq_s_o == (q[1] && c[0]), "R11 irq",
                {30'b0, irq_s_o, irq_ns_o}, {30'b0, q[1] && c[0], q[0]});
         end
      end
      @(negedge clk);
      chk(rsp_vld == 0, "R9 final idle", {31'b0, rsp_vld}, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule